// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block turns one fast source clock into three banks of divided clocks (bank A with five outputs, bank B with five and bank C with four) and one feedback clock. A global pre-scale select doubles every ratio. A select per bank and a two-bit feedback code then pick each bank's divide ratio and the feedback ratio. Every ratio gives a 50 percent duty cycle. All state runs on the rising edge of `clk`, which stands for the VCO-rate clock. In bypass mode the rising edges of one of two reference clocks become the source edges. These edges are detected synchronously and used as a count enable.

An active-low clock-stop input parks all bank outputs low and leaves the feedback output running. A stop or restart takes effect only while an output is already low, so no runt pulse can appear and a restarted output begins with a full high phase. Driving the output-enable input low clears every divider, forces every output low and drops all per-output enable flags. The flags model the tri-state drivers. When the enable rises again, all dividers start together from a common count, so outputs of equal frequency stay phase aligned.

Top module: `clkdiv_banks`

## Requirements
- R1: While `rst` is high or `out_en` is low, every clock output is 0 and every enable flag (`oe_a`, `oe_b`, `oe_c`, `oe_fb`) is 0 from the next clock edge. On the first edge with `rst` low and `out_en` high, all enable flags go to 1.
- R2: Banks A and B divide the source by 4 when their select is 0 and by 8 when it is 1 while `prescale_sel` is 0. They divide by 8 or 16 while `prescale_sel` is 1.
- R3: Bank C divides by 8 when `sel_c` is 0 and by 12 when it is 1 while `prescale_sel` is 0. It divides by 16 or 24 while `prescale_sel` is 1.
- R4: The feedback output divides by 8, 16, 12 or 24 for `fb_sel` values 0, 1, 2 and 3 while `prescale_sel` is 0. It divides by 16, 32, 24 or 48 for the same codes while `prescale_sel` is 1.
- R5: Every output's high phase and low phase each last exactly half of its ratio in source edges.
- R6: With `vco_path_en` at 0, the rising edges of `ref_clk0` (for `ref_sel` = 0) or `ref_clk1` (for `ref_sel` = 1) are the source edges. With `vco_path_en` at 1, every `clk` edge is a source edge.
- R7: With `vco_path_en` at 1, every output makes its first rising edge on the first clock edge after enable, that is, on the edge that samples `out_en` high. Outputs of equal ratio then rise on the same edges.
- R8: While `stop_n` is low, every bank output ends its current high phase at full width and then stays low. The feedback output keeps toggling.
- R9: After `stop_n` returns high, each bank output resumes with a high phase of full width.
- R10: All outputs of one bank carry identical values in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock (VCO rate) |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk0 | input | 1 | Reference clock 0, sampled on `clk` |
| ref_clk1 | input | 1 | Reference clock 1, sampled on `clk` |
| ref_sel | input | 1 | 0 picks `ref_clk0`, 1 picks `ref_clk1` |
| vco_path_en | input | 1 | 1 counts every `clk` edge, 0 counts reference edges (bypass) |
| prescale_sel | input | 1 | Global pre-scale: 1 doubles every ratio |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| fb_sel | input | 2 | Feedback ratio code |
| stop_n | input | 1 | Active-low bank clock stop |
| out_en | input | 1 | Output enable; low clears dividers and disables outputs |
| qa | output | NA | Bank A clock outputs |
| qb | output | NB | Bank B clock outputs |
| qc | output | NC | Bank C clock outputs |
| fb_out | output | 1 | Feedback clock output |
| oe_a | output | NA | Bank A per-output drive enable |
| oe_b | output | NB | Bank B per-output drive enable |
| oe_c | output | NC | Bank C per-output drive enable |
| oe_fb | output | 1 | Feedback drive enable |

## Verification
The assertions assume that the ratio selects, `ref_sel` and `vco_path_en` change only after `out_en` has been low for at least one cycle. The alignment and duty-cycle properties would fire on a change made while the dividers run. They also assume that a chosen reference clock stays at each level for at least two `clk` cycles, so that the synchronizer sees every edge. The stimulus keeps to both rules. It lowers `out_en` and waits a cycle before it reconfigures, and it drives the reference clocks with periods of 6 and 10 cycles at an even duty.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Bank A/B ratio: 4 or 8, doubled by the global pre-scale
  function automatic int unsigned ratio_ab(input logic pre, input logic sel);
    int unsigned base;
    base = sel ? 8 : 4;
    return pre ? base * 2 : base;
  endfunction

  // Bank C ratio: 8 or 12, doubled by the global pre-scale
  function automatic int unsigned ratio_c(input logic pre, input logic sel);
    int unsigned base;
    base = sel ? 12 : 8;
    return pre ? base * 2 : base;
  endfunction

  // Feedback ratio: code bit 1 picks the 8/12 family, bit 0 doubles
  function automatic int unsigned ratio_fb(input logic pre, input logic [1:0] code);
    int unsigned base;
    base = code[1] ? 12 : 8;
    if (code[0]) base = base * 2;
    return pre ? base * 2 : base;
  endfunction

endpackage

// File: rtl/clkdiv_src.sv
module clkdiv_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk0,
  input  logic ref_clk1,
  input  logic ref_sel,
  input  logic vco_path_en,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync0;
  logic [SYNC_STAGES-1:0] sync1;
  logic                   cur;
  logic                   prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          sync0 <= '0;
          sync1 <= '0;
        end else begin
          sync0 <= ref_clk0;
          sync1 <= ref_clk1;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          sync0 <= '0;
          sync1 <= '0;
        end else begin
          sync0 <= {sync0[SYNC_STAGES-2:0], ref_clk0};
          sync1 <= {sync1[SYNC_STAGES-2:0], ref_clk1};
        end
      end
    end
  endgenerate

  assign cur = ref_sel ? sync1[SYNC_STAGES-1] : sync0[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= cur;
  end

  // every fast edge in VCO mode, a detected reference rise in bypass
  assign tick = vco_path_en | (cur & ~prev);

endmodule

// File: rtl/clkdiv_cnt.sv
module clkdiv_cnt #(
  parameter int CNT_W    = 6,
  parameter int NOUT     = 1,
  parameter bit HAS_STOP = 1'b1
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] half,
  input  logic             run,
  output logic [NOUT-1:0]  q
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   last;
  logic             raw;
  logic             raw_d;
  logic             gate;
  logic             gate_d;

  assign last = {half, 1'b0} - 1'b1;

  always_comb begin
    cnt_d = cnt;
    raw_d = raw;
    if (tick) begin
      raw_d = (cnt < half);
      cnt_d = (cnt == last[CNT_W-1:0]) ? '0 : cnt + 1'b1;
    end
  end

  generate
    if (HAS_STOP) begin : g_gate
      // gate may only change while the divided clock is low
      assign gate_d = raw ? gate : run;
    end else begin : g_free
      assign gate_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clear) begin
      cnt  <= '0;
      raw  <= 1'b0;
      gate <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      raw  <= raw_d;
      gate <= gate_d;
    end
  end

  // one registered copy per output pin
  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_rep
      always_ff @(posedge clk) begin
        if (clear) q[i] <= 1'b0;
        else       q[i] <= raw_d & gate_d;
      end
    end
  endgenerate

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int NA          = 5,
  parameter int NB          = 5,
  parameter int NC          = 4,
  parameter int MAX_RATIO   = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_clk0,
  input  logic          ref_clk1,
  input  logic          ref_sel,
  input  logic          vco_path_en,
  input  logic          prescale_sel,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          sel_c,
  input  logic [1:0]    fb_sel,
  input  logic          stop_n,
  input  logic          out_en,
  output logic [NA-1:0] qa,
  output logic [NB-1:0] qb,
  output logic [NC-1:0] qc,
  output logic          fb_out,
  output logic [NA-1:0] oe_a,
  output logic [NB-1:0] oe_b,
  output logic [NC-1:0] oe_c,
  output logic          oe_fb
);

  localparam int CNT_W = $clog2(MAX_RATIO);

  logic             tick;
  logic             clear;
  logic             run_s;
  logic [SYNC_STAGES-1:0] stop_sync;
  logic [CNT_W-1:0] half_a;
  logic [CNT_W-1:0] half_b;
  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] half_fb;

  assign clear = rst | ~out_en;

  assign half_a  = CNT_W'(ratio_ab(prescale_sel, sel_a) / 2);
  assign half_b  = CNT_W'(ratio_ab(prescale_sel, sel_b) / 2);
  assign half_c  = CNT_W'(ratio_c(prescale_sel, sel_c) / 2);
  assign half_fb = CNT_W'(ratio_fb(prescale_sel, fb_sel) / 2);

  generate
    if (SYNC_STAGES == 1) begin : g_stop1
      always_ff @(posedge clk) begin
        if (rst) stop_sync <= '1;
        else     stop_sync <= stop_n;
      end
    end else begin : g_stopn
      always_ff @(posedge clk) begin
        if (rst) stop_sync <= '1;
        else     stop_sync <= {stop_sync[SYNC_STAGES-2:0], stop_n};
      end
    end
  endgenerate
  assign run_s = stop_sync[SYNC_STAGES-1];

  clkdiv_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk         (clk),
    .rst         (rst),
    .ref_clk0    (ref_clk0),
    .ref_clk1    (ref_clk1),
    .ref_sel     (ref_sel),
    .vco_path_en (vco_path_en),
    .tick        (tick)
  );

  clkdiv_cnt #(.CNT_W(CNT_W), .NOUT(NA), .HAS_STOP(1'b1)) u_div_a (
    .clk(clk), .clear(clear), .tick(tick), .half(half_a), .run(run_s), .q(qa)
  );

  clkdiv_cnt #(.CNT_W(CNT_W), .NOUT(NB), .HAS_STOP(1'b1)) u_div_b (
    .clk(clk), .clear(clear), .tick(tick), .half(half_b), .run(run_s), .q(qb)
  );

  clkdiv_cnt #(.CNT_W(CNT_W), .NOUT(NC), .HAS_STOP(1'b1)) u_div_c (
    .clk(clk), .clear(clear), .tick(tick), .half(half_c), .run(run_s), .q(qc)
  );

  clkdiv_cnt #(.CNT_W(CNT_W), .NOUT(1), .HAS_STOP(1'b0)) u_div_fb (
    .clk(clk), .clear(clear), .tick(tick), .half(half_fb), .run(1'b1), .q(fb_out)
  );

  always_ff @(posedge clk) begin
    if (clear) begin
      oe_a  <= '0;
      oe_b  <= '0;
      oe_c  <= '0;
      oe_fb <= 1'b0;
    end else begin
      oe_a  <= '1;
      oe_b  <= '1;
      oe_c  <= '1;
      oe_fb <= 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
  parameter int NA = 5,
  parameter int NB = 5,
  parameter int NC = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          vco_path_en,
  input logic          prescale_sel,
  input logic          sel_a,
  input logic          sel_b,
  input logic [1:0]    fb_sel,
  input logic          stop_n,
  input logic          out_en,
  input logic [NA-1:0] qa,
  input logic [NB-1:0] qb,
  input logic [NC-1:0] qc,
  input logic          fb_out,
  input logic [NA-1:0] oe_a,
  input logic [NB-1:0] oe_b,
  input logic [NC-1:0] oe_c,
  input logic          oe_fb
);

  logic [2:0] cyc;
  logic [7:0] hi_run;
  int         fb_half;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)         hi_run <= '0;
    else if (fb_out) hi_run <= hi_run + 8'd1;
    else             hi_run <= '0;
  end

  always_comb begin
    fb_half = fb_sel[1] ? 6 : 4;
    if (fb_sel[0])    fb_half = fb_half * 2;
    if (prescale_sel) fb_half = fb_half * 2;
  end

  // R1: disabled means silent and undriven
  p_disable_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (qa == '0 && qb == '0 && qc == '0 && !fb_out &&
                 oe_a == '0 && oe_b == '0 && oe_c == '0 && !oe_fb));

  // R1: enabled means every pin driven
  p_enable_drive_r1: assert property (@(posedge clk) disable iff (rst)
    out_en |=> (&oe_a && &oe_b && &oe_c && oe_fb));

  // R10: replicas within a bank agree
  p_replica_r10: assert property (@(posedge clk) disable iff (rst)
    (qa == {NA{qa[0]}} && qb == {NB{qb[0]}} && qc == {NC{qc[0]}}));

  // R7: equal ratios on banks A and B stay in phase
  p_align_ab_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_a == sel_b) |-> (qa[0] == qb[0]));

  // R8: no bank rise once a stop has been seen by the synchronizer
  p_no_rise_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && $rose(qa[0])) |-> $past(stop_n, 3));

  // R5: feedback high phase spans half its ratio in VCO mode
  p_fb_duty_r5: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd2 && $fell(fb_out) && $past(out_en) && vco_path_en)
      |-> (int'(hi_run) == fb_half));

endmodule

bind clkdiv_banks clkdiv_banks_chk #(.NA(NA), .NB(NB), .NC(NC)) u_chk (.*);

// File: tb/clkdiv_banks_test.sv
`timescale 1ns/1ps
module clkdiv_banks_test;

  localparam int NA = 5;
  localparam int NB = 5;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_clk0 = 1'b0;
  logic          ref_clk1 = 1'b0;
  logic          ref_sel = 1'b0;
  logic          vco_path_en = 1'b1;
  logic          prescale_sel = 1'b0;
  logic          sel_a = 1'b0;
  logic          sel_b = 1'b0;
  logic          sel_c = 1'b0;
  logic [1:0]    fb_sel = 2'b00;
  logic          stop_n = 1'b1;
  logic          out_en = 1'b0;
  logic [NA-1:0] qa;
  logic [NB-1:0] qb;
  logic [NC-1:0] qc;
  logic          fb_out;
  logic [NA-1:0] oe_a;
  logic [NB-1:0] oe_b;
  logic [NC-1:0] oe_c;
  logic          oe_fb;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clkdiv_banks uut (
    .clk(clk), .rst(rst), .ref_clk0(ref_clk0), .ref_clk1(ref_clk1),
    .ref_sel(ref_sel), .vco_path_en(vco_path_en), .prescale_sel(prescale_sel),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .fb_sel(fb_sel),
    .stop_n(stop_n), .out_en(out_en), .qa(qa), .qb(qb), .qc(qc),
    .fb_out(fb_out), .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c), .oe_fb(oe_fb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ab(input int pre, input int sel);
    return (4 << sel) << pre;
  endfunction
  function automatic int exp_c(input int pre, input int sel);
    return (sel != 0 ? 12 : 8) << pre;
  endfunction
  function automatic int exp_fb(input int pre, input int code);
    return ((code >= 2 ? 12 : 8) << (code % 2)) << pre;
  endfunction

  function automatic int quiet_all();
    return (qa == '0 && qb == '0 && qc == '0 && !fb_out &&
            oe_a == '0 && oe_b == '0 && oe_c == '0 && !oe_fb) ? 1 : 0;
  endfunction

  // reference clocks: period 6 on ref_clk0, period 10 on ref_clk1
  initial begin
    int c0 = 0;
    int c1 = 0;
    forever begin
      @(negedge clk);
      c0 = (c0 + 1) % 6;
      c1 = (c1 + 1) % 10;
      ref_clk0 = (c0 < 3);
      ref_clk1 = (c1 < 5);
    end
  end

  // watchdog
  initial begin
    #(4.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // disable, configure, release; then record edges of the first output of each bank
  task automatic measure(input int len, input int n_exp[4], input string tag);
    int r1[4];
    int r2[4];
    int f1[4];
    int pv[4];
    int v[4];
    int rep_bad = 0;
    for (int k = 0; k < 4; k++) begin
      r1[k] = -1; r2[k] = -1; f1[k] = -1; pv[k] = 0;
    end
    out_en = 1'b1;
    for (int t = 1; t <= len; t++) begin
      @(negedge clk);
      v[0] = int'(qa[0]); v[1] = int'(qb[0]); v[2] = int'(qc[0]); v[3] = int'(fb_out);
      if (qa != {NA{qa[0]}} || qb != {NB{qb[0]}} || qc != {NC{qc[0]}}) rep_bad++;
      if (t == 1) chk("R1 enable flags high", (&oe_a && &oe_b && &oe_c && oe_fb) ? 1 : 0, 1);
      for (int k = 0; k < 4; k++) begin
        if (v[k] == 1 && pv[k] == 0) begin
          if (r1[k] < 0) r1[k] = t;
          else if (r2[k] < 0) r2[k] = t;
        end
        if (v[k] == 0 && pv[k] == 1 && f1[k] < 0) f1[k] = t;
        pv[k] = v[k];
      end
    end
    chk({"R10 replicas ", tag}, rep_bad, 0);
    for (int k = 0; k < 4; k++) begin
      if (n_exp[k] > 0) begin
        if (tag == "vco") chk($sformatf("R7 first rise out%0d", k), r1[k], 1);
        chk($sformatf("R2 R3 R4 R6 period out%0d %s", k, tag), r2[k] - r1[k], n_exp[k]);
        chk($sformatf("R5 high phase out%0d %s", k, tag), f1[k] - r1[k], n_exp[k] / 2);
      end
    end
  endtask

  task automatic disable_and_set(input int pre, input int s, input int f);
    @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    prescale_sel = pre[0];
    sel_a = s[0]; sel_b = s[1]; sel_c = s[2];
    fb_sel = f[1:0];
    @(negedge clk);
  endtask

  initial begin
    int n[4];
    // reset state
    out_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state quiet", quiet_all(), 1);
    rst = 1'b0;
    out_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 disabled after reset", quiet_all(), 1);

    // exhaustive VCO-mode sweep: R2 R3 R4 R5 R7 R10
    for (int pre = 0; pre < 2; pre++) begin
      for (int s = 0; s < 8; s++) begin
        for (int f = 0; f < 4; f++) begin
          disable_and_set(pre, s, f);
          chk("R1 quiet while disabled", quiet_all(), 1);
          n[0] = exp_ab(pre, s % 2);
          n[1] = exp_ab(pre, (s / 2) % 2);
          n[2] = exp_c(pre, s / 4);
          n[3] = exp_fb(pre, f);
          measure(2 * n[3] + 8, n, "vco");
        end
      end
    end

    // bypass: R6 with each reference
    for (int rs = 0; rs < 2; rs++) begin
      int per;
      per = (rs == 0) ? 6 : 10;
      disable_and_set(0, 5, 3);
      vco_path_en = 1'b0;
      ref_sel = rs[0];
      n[0] = 8 * per;
      n[1] = 0;
      n[2] = 12 * per;
      n[3] = 24 * per;
      measure(2 * n[3] + 3 * per + 10, n, "bypass");
    end
    vco_path_en = 1'b1;
    ref_sel = 1'b0;

    // clock stop and restart: R8 R9
    begin
      int pa;
      int pb;
      int wa;
      int wb;
      int runt = 0;
      int bank_hi = 0;
      int fb_rises = 0;
      int pf = 0;
      int seen_rise_a = 0;
      disable_and_set(0, 1, 0);    // A ratio 8, B ratio 4, C ratio 8, fb ratio 8
      out_en = 1'b1;
      pa = 0; pb = 0; wa = 0; wb = 0;
      for (int t = 1; t <= 220; t++) begin
        @(negedge clk);
        if (t == 31) stop_n = 1'b0;
        if (t == 121) stop_n = 1'b1;
        if (qa[0]) wa++;
        if (qb[0]) wb++;
        if (!qa[0] && pa == 1) begin
          if (wa != 4) runt++;
          wa = 0;
        end
        if (!qb[0] && pb == 1) begin
          if (wb != 2) runt++;
          wb = 0;
        end
        if (t >= 70 && t <= 120) begin
          if (qa != '0 || qb != '0 || qc != '0) bank_hi++;
          if (fb_out && pf == 0) fb_rises++;
        end
        if (t > 121 && qa[0] && pa == 0) seen_rise_a = 1;
        pa = int'(qa[0]);
        pb = int'(qb[0]);
        pf = int'(fb_out);
      end
      chk("R8 banks parked low", bank_hi, 0);
      chk("R8 feedback keeps running", (fb_rises >= 5) ? 1 : 0, 1);
      chk("R8 R9 no runt pulses", runt, 0);
      chk("R9 bank resumes", seen_rise_a, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule